// File: doc/BRIEF.md
# Paged Management-to-Register Bridge

This block lets a management agent that only speaks 16-bit clause-22 transactions reach a switch's 32-bit internal register space. A clause-22 decoder in front of the block presents one already-framed transaction per cycle: PHY address, register number, direction, 16-bit write data and a valid strobe. The bridge turns these into accesses on a 32-bit register bus and returns 16-bit read data a fixed two cycles later.

A 9-bit page register holds the top bits of the word address. The low seven word-address bits come from the transaction itself: three bits from the PHY address and four bits from the register number. The least significant register-number bit picks the half-word. A 32-bit value is therefore reached through a pair of adjacent register numbers, and the ordering of the two halves makes each 32-bit write and read behave as one access.

Software writes the high half first and then the low half, so the low half commits the whole word. Software reads the low half first and then the high half, so the low half samples the whole word. Transactions aimed at PHY addresses the bridge does not own are dropped.

Top module: `mdio_page_bridge`

## Requirements
- R1: After reset the page is 0, both half-word latches hold 0, `reg_we`, `reg_re` and `mgmt_rvalid` are low and `mgmt_rdata` is 0.
- R2: A write to PHY address 0x1F, register 0x10 loads `mgmt_wdata[8:0]` into the page. A read of that same location returns the page zero-extended to 16 bits. No other transaction changes the page.
- R3: For a data access the word address on `reg_addr` is {page[8:0], phy[2:0], reg[4:1]}. Only PHY addresses 0x10 to 0x17 are data accesses.
- R4: A data write to an odd register number only stores the 16-bit value in the write latch. It issues no bus write.
- R5: A data write to an even register number raises `reg_we` for exactly one cycle, one cycle after the transaction. `reg_wdata` carries the write latch in bits [31:16] and the new value in bits [15:0]. `reg_we` and `reg_re` are never high together.
- R6: A data read of an even register number raises `reg_re` for one cycle, one cycle after the transaction. `reg_rdata[15:0]` is then returned, and `reg_rdata[31:16]` is stored in the read latch.
- R7: A data read of an odd register number makes no bus access and returns the read latch.
- R8: A transaction to any PHY address outside 0x10 to 0x17 other than the page location causes no bus access and changes neither the page nor any latch. A read of such an address returns 0xFFFF.
- R9: Every read transaction produces exactly one `mgmt_rvalid` pulse, two cycles after it, with `mgmt_rdata` valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mgmt_valid | input | 1 | Transaction strobe, one cycle per transaction |
| mgmt_phy | input | 5 | PHY address of the transaction |
| mgmt_reg | input | 5 | Register number of the transaction |
| mgmt_write | input | 1 | 1 = write, 0 = read |
| mgmt_wdata | input | 16 | Write data |
| mgmt_rdata | output | 16 | Read data returned to the management side |
| mgmt_rvalid | output | 1 | Read data valid pulse |
| reg_we | output | 1 | Register bus write strobe |
| reg_re | output | 1 | Register bus read strobe |
| reg_addr | output | 16 | Register bus word address |
| reg_wdata | output | 32 | Register bus write data |
| reg_rdata | input | 32 | Register bus read data, valid in the cycle of `reg_re` |

## Verification
Random sequences mix page writes, high-then-low write pairs, low-then-high read pairs, page readback and accesses to foreign PHY addresses across all eight data PHY addresses and all sixteen register pairs. Each kind of sequence separates a different fault: a wrong address field position, a write that commits on the wrong half, a stale or missing read latch, or a foreign access that leaks into state. Directed cases add the page at its top value 0x1FF, a low half written with no preceding high half, repeated high-half reads, a foreign write placed between the two halves of a write, and a reset in the middle of traffic.

// File: rtl/mdio_bridge_pkg.sv
package mdio_bridge_pkg;

    // Classification of one management transaction
    typedef enum logic [1:0] {
        ACC_NONE = 2'd0,
        ACC_PAGE = 2'd1,
        ACC_DATA = 2'd2
    } acc_kind_e;

    // Where the returned read half-word comes from
    typedef enum logic [1:0] {
        RSRC_BUS  = 2'd0,
        RSRC_HI   = 2'd1,
        RSRC_PAGE = 2'd2,
        RSRC_ONES = 2'd3
    } rsrc_e;

    localparam int MGMT_AW = 5;
    localparam int HALF_W  = 16;
    localparam int WORD_W  = 2 * HALF_W;

endpackage

// File: rtl/mdio_addr_decode.sv
module mdio_addr_decode
    import mdio_bridge_pkg::*;
#(
    parameter int                 PAGE_W   = 9,
    parameter logic [MGMT_AW-1:0] PAGE_PHY = 5'h1F,
    parameter logic [MGMT_AW-1:0] PAGE_REG = 5'h10,
    localparam int                ADDR_W   = PAGE_W + 7
) (
    input  logic [MGMT_AW-1:0] phy,
    input  logic [MGMT_AW-1:0] regn,
    input  logic [PAGE_W-1:0]  page,
    output acc_kind_e          kind,
    output logic               half_hi,
    output logic [ADDR_W-1:0]  word_addr
);

    always_comb begin
        if (phy == PAGE_PHY && regn == PAGE_REG) begin
            kind = ACC_PAGE;
        end else if (phy[4:3] == 2'b10) begin
            kind = ACC_DATA;
        end else begin
            kind = ACC_NONE;
        end
        half_hi   = regn[0];
        word_addr = {page, phy[2:0], regn[4:1]};
    end

endmodule

// File: rtl/mdio_bridge_core.sv
module mdio_bridge_core
    import mdio_bridge_pkg::*;
#(
    parameter int  PAGE_W = 9,
    localparam int ADDR_W = PAGE_W + 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid,
    input  logic              write,
    input  logic [HALF_W-1:0] wdata,
    input  acc_kind_e         kind,
    input  logic              half_hi,
    input  logic [ADDR_W-1:0] word_addr,
    input  logic [WORD_W-1:0] bus_rdata,
    output logic [PAGE_W-1:0] page,
    output logic              bus_we,
    output logic              bus_re,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [WORD_W-1:0] bus_wdata,
    output logic [HALF_W-1:0] rdata,
    output logic              rvalid
);

    typedef struct packed {
        logic [PAGE_W-1:0] page;
        logic [HALF_W-1:0] wr_hi;
        logic [HALF_W-1:0] rd_hi;
        logic              we;
        logic              re;
        logic [ADDR_W-1:0] addr;
        logic [WORD_W-1:0] wdat;
        logic              rd_pend;
        rsrc_e             rd_src;
        logic [HALF_W-1:0] rdat;
        logic              rvld;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d         = st_q;
        st_d.we      = 1'b0;
        st_d.re      = 1'b0;
        st_d.rd_pend = 1'b0;
        st_d.rvld    = 1'b0;

        // second stage: return read data
        if (st_q.rd_pend) begin
            st_d.rvld = 1'b1;
            case (st_q.rd_src)
                RSRC_BUS: begin
                    st_d.rdat  = bus_rdata[HALF_W-1:0];
                    st_d.rd_hi = bus_rdata[WORD_W-1:HALF_W];
                end
                RSRC_HI:   st_d.rdat = st_q.rd_hi;
                RSRC_PAGE: st_d.rdat = {{(HALF_W-PAGE_W){1'b0}}, st_q.page};
                default:   st_d.rdat = '1;
            endcase
        end

        // first stage: accept a transaction
        if (valid) begin
            case (kind)
                ACC_PAGE: begin
                    if (write) begin
                        st_d.page = wdata[PAGE_W-1:0];
                    end else begin
                        st_d.rd_pend = 1'b1;
                        st_d.rd_src  = RSRC_PAGE;
                    end
                end
                ACC_DATA: begin
                    if (write) begin
                        if (half_hi) begin
                            st_d.wr_hi = wdata;
                        end else begin
                            st_d.we   = 1'b1;
                            st_d.addr = word_addr;
                            st_d.wdat = {st_q.wr_hi, wdata};
                        end
                    end else begin
                        st_d.rd_pend = 1'b1;
                        if (half_hi) begin
                            st_d.rd_src = RSRC_HI;
                        end else begin
                            st_d.rd_src = RSRC_BUS;
                            st_d.re     = 1'b1;
                            st_d.addr   = word_addr;
                        end
                    end
                end
                default: begin
                    if (!write) begin
                        st_d.rd_pend = 1'b1;
                        st_d.rd_src  = RSRC_ONES;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign page      = st_q.page;
    assign bus_we    = st_q.we;
    assign bus_re    = st_q.re;
    assign bus_addr  = st_q.addr;
    assign bus_wdata = st_q.wdat;
    assign rdata     = st_q.rdat;
    assign rvalid    = st_q.rvld;

    // R4
    hi_wr_no_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && write && kind == ACC_DATA && half_hi) |=> !bus_we);

    // R5
    lo_wr_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && write && kind == ACC_DATA && !half_hi) |=>
            (bus_we && bus_wdata[HALF_W-1:0] == $past(wdata)
                    && bus_wdata[WORD_W-1:HALF_W] == $past(st_q.wr_hi)));

    // R5
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({bus_we, bus_re}));

    // R8
    foreign_no_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && kind == ACC_NONE) |=> (!bus_we && !bus_re));

    // R2
    page_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(valid && write && kind == ACC_PAGE) |=> $stable(page));

    // R9
    rvalid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_re |=> rvalid);

    // R9
    rvalid_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid |-> $past(st_q.rd_pend));

endmodule

// File: rtl/mdio_page_bridge.sv
module mdio_page_bridge
    import mdio_bridge_pkg::*;
#(
    parameter int                 PAGE_W   = 9,
    parameter logic [MGMT_AW-1:0] PAGE_PHY = 5'h1F,
    parameter logic [MGMT_AW-1:0] PAGE_REG = 5'h10,
    localparam int                ADDR_W   = PAGE_W + 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mgmt_valid,
    input  logic [4:0]        mgmt_phy,
    input  logic [4:0]        mgmt_reg,
    input  logic              mgmt_write,
    input  logic [15:0]       mgmt_wdata,
    output logic [15:0]       mgmt_rdata,
    output logic              mgmt_rvalid,
    output logic              reg_we,
    output logic              reg_re,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [31:0]       reg_wdata,
    input  logic [31:0]       reg_rdata
);

    acc_kind_e         kind;
    logic              half_hi;
    logic [ADDR_W-1:0] word_addr;
    logic [PAGE_W-1:0] page;

    mdio_addr_decode #(
        .PAGE_W  (PAGE_W),
        .PAGE_PHY(PAGE_PHY),
        .PAGE_REG(PAGE_REG)
    ) u_decode (
        .phy      (mgmt_phy),
        .regn     (mgmt_reg),
        .page     (page),
        .kind     (kind),
        .half_hi  (half_hi),
        .word_addr(word_addr)
    );

    mdio_bridge_core #(
        .PAGE_W(PAGE_W)
    ) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .valid    (mgmt_valid),
        .write    (mgmt_write),
        .wdata    (mgmt_wdata),
        .kind     (kind),
        .half_hi  (half_hi),
        .word_addr(word_addr),
        .bus_rdata(reg_rdata),
        .page     (page),
        .bus_we   (reg_we),
        .bus_re   (reg_re),
        .bus_addr (reg_addr),
        .bus_wdata(reg_wdata),
        .rdata    (mgmt_rdata),
        .rvalid   (mgmt_rvalid)
    );

endmodule

// File: tb/mdio_page_bridge_tb.sv
`timescale 1ns/1ps
module mdio_page_bridge_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mgmt_valid = 1'b0;
    logic [4:0]  mgmt_phy = '0;
    logic [4:0]  mgmt_reg = '0;
    logic        mgmt_write = 1'b0;
    logic [15:0] mgmt_wdata = '0;
    logic [15:0] mgmt_rdata;
    logic        mgmt_rvalid;
    logic        reg_we, reg_re;
    logic [15:0] reg_addr;
    logic [31:0] reg_wdata, reg_rdata;

    int checks = 0, fails = 0;
    int wr_seen = 0, wr_exp = 0;
    bit done = 0;

    logic [8:0]  page_m = '0;
    logic [15:0] whi_m = '0, rhi_m = '0;

    always #2.5 clk = ~clk;

    function automatic logic [31:0] bus_val(input logic [15:0] a);
        return {a ^ 16'hC3A5, ~a};
    endfunction

    assign reg_rdata = bus_val(reg_addr);

    mdio_page_bridge u_dut (
        .clk(clk), .rst_n(rst_n), .mgmt_valid(mgmt_valid), .mgmt_phy(mgmt_phy),
        .mgmt_reg(mgmt_reg), .mgmt_write(mgmt_write), .mgmt_wdata(mgmt_wdata),
        .mgmt_rdata(mgmt_rdata), .mgmt_rvalid(mgmt_rvalid), .reg_we(reg_we),
        .reg_re(reg_re), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata)
    );

    always @(posedge clk) if (rst_n && reg_we) wr_seen++;

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one transaction from a negedge, with bench-side expectations
    task automatic op(input logic [4:0] p, input logic [4:0] r, input bit w,
                      input logic [15:0] d);
        bit is_page = (p == 5'h1F && r == 5'h10);
        bit is_data = (p[4:3] == 2'b10);
        logic [15:0] a = {page_m, p[2:0], r[4:1]};
        logic [15:0] exp_rd;
        mgmt_valid = 1'b1; mgmt_phy = p; mgmt_reg = r;
        mgmt_write = w; mgmt_wdata = d;
        @(negedge clk);
        mgmt_valid = 1'b0;
        if (w) begin
            if (is_page) begin
                page_m = d[8:0];
                chk(!reg_we, "R2 page write no bus", {31'd0, reg_we}, 0);
            end else if (is_data && r[0]) begin
                whi_m = d;
                chk(!reg_we, "R4 high write no bus", {31'd0, reg_we}, 0);
            end else if (is_data) begin
                wr_exp++;
                chk(reg_we && reg_addr == a, "R3 R5 write addr", {reg_we, 15'd0, reg_addr},
                    {1'b1, 15'd0, a});
                chk(reg_wdata == {whi_m, d}, "R5 write data", reg_wdata, {whi_m, d});
            end else begin
                chk(!reg_we && !reg_re, "R8 foreign write no bus", {reg_we, reg_re}, 0);
            end
        end else begin
            if (is_page) exp_rd = {7'd0, page_m};
            else if (is_data && r[0]) exp_rd = rhi_m;
            else if (is_data) begin
                exp_rd = bus_val(a)[15:0];
                rhi_m  = bus_val(a)[31:16];
                chk(reg_re && reg_addr == a, "R3 R6 read strobe addr",
                    {reg_re, 15'd0, reg_addr}, {1'b1, 15'd0, a});
            end else begin
                exp_rd = 16'hFFFF;
                chk(!reg_re && !reg_we, "R8 foreign read no bus", {reg_we, reg_re}, 0);
            end
            if (is_page || (is_data && r[0]))
                chk(!reg_re, "R7 no bus read", {31'd0, reg_re}, 0);
            chk(!mgmt_rvalid, "R9 rvalid not early", {31'd0, mgmt_rvalid}, 0);
            @(negedge clk);
            chk(mgmt_rvalid && mgmt_rdata == exp_rd, "R6 R7 R9 read data",
                {mgmt_rvalid, 15'd0, mgmt_rdata}, {1'b1, 15'd0, exp_rd});
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        page_m = '0; whi_m = '0; rhi_m = '0;
        chk(!reg_we && !reg_re && !mgmt_rvalid && mgmt_rdata == 0, "R1 reset outputs",
            {reg_we, reg_re, mgmt_rvalid, 13'd0, mgmt_rdata}, 0);
    endtask

    function automatic logic [4:0] foreign_phy(input int unsigned v);
        int unsigned x = v % 23;
        return (x < 16) ? 5'(x) : 5'(x + 8);
    endfunction

    initial begin
        int unsigned s;
        s = $urandom(32'hBEEF);
        @(negedge clk);
        do_reset();

        // R1 latches clear: high read gives 0, low write has zero high half
        op(5'h13, 5'h05, 0, 0);
        op(5'h10, 5'h00, 1, 16'h1234);
        chk(reg_wdata == 32'h0000_1234, "R1 R5 write latch cleared", reg_wdata, 32'h0000_1234);

        // R2 page write and readback, R3 top page address
        op(5'h1F, 5'h10, 1, 16'hFFFF);
        op(5'h1F, 5'h10, 0, 0);
        op(5'h17, 5'h1F, 1, 16'hBEEF);
        op(5'h17, 5'h1E, 1, 16'hCAFE);
        chk(reg_addr == 16'hFFFF && reg_wdata == 32'hBEEF_CAFE, "R3 top address",
            {reg_addr, 16'd0}, {16'hFFFF, 16'd0});
        op(5'h1F, 5'h10, 1, 16'h00A5);
        op(5'h12, 5'h0C, 0, 0);
        op(5'h12, 5'h0D, 0, 0);
        op(5'h12, 5'h0D, 0, 0);

        // R8 foreign accesses leave page and latches alone
        op(5'h11, 5'h03, 1, 16'h5555);
        op(5'h1F, 5'h11, 1, 16'h0001);
        op(5'h05, 5'h02, 1, 16'hAAAA);
        op(5'h18, 5'h03, 1, 16'h7777);
        op(5'h11, 5'h02, 1, 16'h6666);
        chk(reg_wdata == 32'h5555_6666, "R8 latch kept", reg_wdata, 32'h5555_6666);
        op(5'h1F, 5'h10, 0, 0);
        op(5'h05, 5'h00, 0, 0);
        op(5'h1F, 5'h00, 0, 0);
        op(5'h14, 5'h09, 0, 0);

        for (int i = 0; i < 400; i++) begin
            int unsigned k = $urandom % 6;
            logic [4:0] p = 5'h10 | 5'($urandom % 8);
            logic [4:0] r = 5'(($urandom % 16) << 1);
            logic [15:0] d1 = 16'($urandom);
            logic [15:0] d2 = 16'($urandom);
            case (k)
                0: op(5'h1F, 5'h10, 1, d1);
                1: begin op(p, r | 5'd1, 1, d1); op(p, r, 1, d2); end
                2: begin op(p, r, 0, 0); op(p, r | 5'd1, 0, 0); end
                3: op(foreign_phy($urandom), 5'($urandom), 1'($urandom), d1);
                4: op(5'h1F, 5'h10, 0, 0);
                default: op(p, r | 5'd1, 1'($urandom), d1);
            endcase
        end

        // R1 reset in the middle of traffic
        op(5'h1F, 5'h10, 1, 16'h0133);
        op(5'h16, 5'h07, 1, 16'h9999);
        op(5'h16, 5'h06, 0, 0);
        do_reset();
        op(5'h1F, 5'h10, 0, 0);
        op(5'h16, 5'h07, 0, 0);
        op(5'h16, 5'h06, 1, 16'h4321);
        chk(reg_addr == 16'h0063 && reg_wdata == 32'h0000_4321, "R1 state after reset",
            reg_wdata, 32'h0000_4321);

        @(negedge clk);
        @(negedge clk);
        chk(wr_seen == wr_exp, "R5 one bus write per low half", wr_seen, wr_exp);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule